// File: doc/BRIEF.md
# Programmable Raster Sync Generator

This block produces the horizontal sync, vertical sync, a visible-area flag and the current pixel and line coordinates for a raster display. Its timing does not come from fixed constants. Eight timing registers can be loaded while the block runs, through a small write port made of a 14-bit data bus, a 3-bit register address and a write enable. The register values are lengths. The block turns them into start and stop positions, and each output flag is then set and cleared by plain equality compares against those positions.

Software writes a mode into a staging bank whenever it likes. The generator copies the whole bank into its working set at the wrap from the last pixel of the last line, so a frame that has already started always finishes with the timing it began with. Each sync has its own polarity bit. The vertical sync moves only in the cycle where the horizontal sync becomes active. The front porch is not stored. It is whatever is left of the total, so the picture can be moved by trading back porch against total. A line-doubled mode is loaded by doubling every vertical value and running the block on a clock twice as fast.

Top module: `raster_timer`

## Requirements
- R1: Reset loads a horizontal mode of total 695, sync 56, back porch 121 and visible 500 (front porch 18). It loads a vertical mode of total 417, sync 3, back porch 25 and visible 378 (front porch 11). Both syncs are active-low. While reset is held the outputs show pixel 0 of line 0 with both syncs asserted and visible low.
- R2: A write with cfg_we high stores cfg_data into the staging register selected by cfg_addr on that clock edge. The addresses are: 0 horizontal total, 1 horizontal sync length in bits 12:0 with the horizontal polarity in bit 13, 2 horizontal back porch, 3 horizontal visible length, 4 vertical total, 5 vertical sync length in bits 12:0 with the vertical polarity in bit 13, 6 vertical back porch, 7 vertical visible length.
- R3: Staged values take effect from the first pixel of the next frame. The frame in progress keeps its old timing completely, including its polarity.
- R4: pix_x counts 0 to horizontal total minus 1 and then wraps. line_y advances by one at each wrap of pix_x and wraps to 0 after vertical total minus 1.
- R5: The horizontal sync is active exactly while pix_x is below the horizontal sync length.
- R6: The vertical sync is active exactly while line_y is below the vertical sync length. It changes level only in a cycle where the horizontal sync becomes active.
- R7: visible is high exactly when pix_x lies in [hsync+hback, hsync+hback+hvisible) and line_y lies in [vsync+vback, vsync+vback+vvisible). This also holds when the front porch is zero.
- R8: A polarity bit of 1 makes that sync active-high, and 0 makes it active-low. The horizontal and vertical bits are independent.
- R9: Moving lengths between back porch and front porch while the total stays the same shifts the visible window by the same number of pixels.
- R10: A line-doubled mode (every vertical value doubled, horizontal values unchanged) produces twice the lines with the same line pattern.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| cfg_we | input | 1 | Write enable for the timing register port |
| cfg_addr | input | 3 | Timing register select |
| cfg_data | input | 14 | Timing register write data |
| hsync | output | 1 | Horizontal sync with the selected polarity applied |
| vsync | output | 1 | Vertical sync with the selected polarity applied |
| visible | output | 1 | High while the current position is inside the visible window |
| pix_x | output | 14 | Current pixel position within the line |
| line_y | output | 14 | Current line within the frame |

## Verification
The hardest situation to reach is a register write that lands in the middle of a running frame. This is the point where a missing shadow stage would bend the current frame but still produce a correct next frame. The stimulus therefore issues each new mode's eight writes in parallel with a cycle-exact scan of the frame already in progress, and checks that frame against the old mode before checking the next frame against the new one. The modes in the table also cover a polarity swap, a porch shift at constant total, a doubled vertical mode and a mode with no front porch, where the visible window must close at the wrap itself.

// File: rtl/raster_timer_pkg.sv
package raster_timer_pkg;

  localparam int CW      = 14;
  localparam int AW      = 3;
  localparam int NREG    = 2 ** AW;
  localparam int POL_BIT = CW - 1;

  typedef logic [CW-1:0] cnt_t;
  typedef logic [NREG-1:0][CW-1:0] bank_t;

  typedef enum logic [AW-1:0] {
    A_HTOT = 3'd0,
    A_HSYN = 3'd1,
    A_HBCK = 3'd2,
    A_HVIS = 3'd3,
    A_VTOT = 3'd4,
    A_VSYN = 3'd5,
    A_VBCK = 3'd6,
    A_VVIS = 3'd7
  } cfg_addr_e;

  // Working set: positions precomputed once per frame so that the
  // per-pixel compares are pure equality.
  typedef struct packed {
    cnt_t h_last;
    cnt_t h_sync_end;
    cnt_t h_vis_beg;
    cnt_t h_vis_end;
    cnt_t v_last;
    cnt_t v_sync_end;
    cnt_t v_vis_beg;
    cnt_t v_vis_end;
    logic h_hi;
    logic v_hi;
  } active_t;

  function automatic active_t derive_active(input bank_t b);
    active_t d;
    cnt_t    hs;
    cnt_t    vs;
    hs = {1'b0, b[A_HSYN][CW-2:0]};
    vs = {1'b0, b[A_VSYN][CW-2:0]};
    d.h_last     = b[A_HTOT] - 1'b1;
    d.h_sync_end = hs;
    d.h_vis_beg  = hs + b[A_HBCK];
    d.h_vis_end  = hs + b[A_HBCK] + b[A_HVIS];
    d.v_last     = b[A_VTOT] - 1'b1;
    d.v_sync_end = vs;
    d.v_vis_beg  = vs + b[A_VBCK];
    d.v_vis_end  = vs + b[A_VBCK] + b[A_VVIS];
    d.h_hi       = b[A_HSYN][POL_BIT];
    d.v_hi       = b[A_VSYN][POL_BIT];
    return d;
  endfunction

endpackage

// File: rtl/rt_cfg_bank.sv
module rt_cfg_bank
  import raster_timer_pkg::*;
#(
  parameter int unsigned RST_H_TOTAL = 695,
  parameter int unsigned RST_H_SYNC  = 56,
  parameter int unsigned RST_H_BACK  = 121,
  parameter int unsigned RST_H_VIS   = 500,
  parameter int unsigned RST_V_TOTAL = 417,
  parameter int unsigned RST_V_SYNC  = 3,
  parameter int unsigned RST_V_BACK  = 25,
  parameter int unsigned RST_V_VIS   = 378,
  parameter bit          RST_H_HI    = 1'b0,
  parameter bit          RST_V_HI    = 1'b0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [CW-1:0] wr_data,
  input  logic          frame_wrap,
  output active_t       act
);

  function automatic bank_t reset_bank();
    bank_t b;
    b         = '0;
    b[A_HTOT] = CW'(RST_H_TOTAL);
    b[A_HSYN] = CW'(RST_H_SYNC) | (CW'(RST_H_HI) << POL_BIT);
    b[A_HBCK] = CW'(RST_H_BACK);
    b[A_HVIS] = CW'(RST_H_VIS);
    b[A_VTOT] = CW'(RST_V_TOTAL);
    b[A_VSYN] = CW'(RST_V_SYNC) | (CW'(RST_V_HI) << POL_BIT);
    b[A_VBCK] = CW'(RST_V_BACK);
    b[A_VVIS] = CW'(RST_V_VIS);
    return b;
  endfunction

  localparam bank_t   RST_BANK = reset_bank();
  localparam active_t RST_ACT  = derive_active(RST_BANK);

  bank_t   stg_q, stg_d;
  active_t act_q, act_d;

  // Staging bank: written at any time.
  always_comb begin
    stg_d = stg_q;
    if (wr_en) begin
      stg_d[wr_addr] = wr_data;
    end
  end

  // Working set: copied from the staging bank only at the frame wrap.
  always_comb begin
    act_d = act_q;
    if (frame_wrap) begin
      act_d = derive_active(stg_q);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg_q <= RST_BANK;
      act_q <= RST_ACT;
    end else begin
      stg_q <= stg_d;
      act_q <= act_d;
    end
  end

  assign act = act_q;

  for (genvar g = 0; g < NREG; g++) begin : g_wr_chk
    // R2: an addressed write lands in its own staging slot
    p_stage_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr == AW'(g)) |=> (stg_q[g] == $past(wr_data)));
  end

  // R3: the working set never moves inside a frame
  p_frame_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_wrap |=> $stable(act_q));

endmodule

// File: rtl/rt_scan_counter.sv
module rt_scan_counter
  import raster_timer_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  cnt_t h_last,
  input  cnt_t v_last,
  output cnt_t x_q,
  output cnt_t y_q,
  output logic frame_wrap
);

  cnt_t x_d, y_d;
  logic line_end;

  assign line_end   = (x_q == h_last);
  assign frame_wrap = line_end && (y_q == v_last);

  always_comb begin
    x_d = x_q + 1'b1;
    y_d = y_q;
    if (line_end) begin
      x_d = '0;
      y_d = (y_q == v_last) ? '0 : (y_q + 1'b1);
    end
  end

  // Runs one position ahead of the registered outputs: position 0 is
  // already shown during reset, so the counter restarts at 1.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      x_q <= cnt_t'(1);
      y_q <= '0;
    end else begin
      x_q <= x_d;
      y_q <= y_d;
    end
  end

  // R4: the pixel position never passes the end of the line
  p_x_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    x_q <= h_last);

  // R4: the line only moves on a line wrap
  p_y_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !line_end |=> $stable(y_q));

endmodule

// File: rtl/rt_span.sv
module rt_span
  import raster_timer_pkg::*;
#(
  parameter bit RST_Q = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  cnt_t pos,
  input  cnt_t beg,
  input  cnt_t fin,
  output logic q
);

  logic q_d;

  // Set on the start position, cleared on the stop position or at the
  // wrap, which closes a window that runs to the end of its axis.
  always_comb begin
    q_d = q;
    if (en) begin
      if (pos == beg) begin
        q_d = 1'b1;
      end else if ((pos == fin) || (pos == '0)) begin
        q_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= RST_Q;
    end else begin
      q <= q_d;
    end
  end

endmodule

// File: rtl/raster_timer.sv
module raster_timer
  import raster_timer_pkg::*;
#(
  parameter int unsigned RST_H_TOTAL = 695,
  parameter int unsigned RST_H_SYNC  = 56,
  parameter int unsigned RST_H_BACK  = 121,
  parameter int unsigned RST_H_VIS   = 500,
  parameter int unsigned RST_V_TOTAL = 417,
  parameter int unsigned RST_V_SYNC  = 3,
  parameter int unsigned RST_V_BACK  = 25,
  parameter int unsigned RST_V_VIS   = 378,
  parameter bit          RST_H_HI    = 1'b0,
  parameter bit          RST_V_HI    = 1'b0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [AW-1:0] cfg_addr,
  input  logic [CW-1:0] cfg_data,
  output logic          hsync,
  output logic          vsync,
  output logic          visible,
  output logic [CW-1:0] pix_x,
  output logic [CW-1:0] line_y
);

  localparam int NAX = 2;  // axis 0 horizontal, axis 1 vertical

  active_t act;
  cnt_t    cx, cy;
  logic    frame_wrap;

  rt_cfg_bank #(
    .RST_H_TOTAL(RST_H_TOTAL), .RST_H_SYNC(RST_H_SYNC),
    .RST_H_BACK (RST_H_BACK),  .RST_H_VIS (RST_H_VIS),
    .RST_V_TOTAL(RST_V_TOTAL), .RST_V_SYNC(RST_V_SYNC),
    .RST_V_BACK (RST_V_BACK),  .RST_V_VIS (RST_V_VIS),
    .RST_H_HI   (RST_H_HI),    .RST_V_HI  (RST_V_HI)
  ) u_cfg (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (cfg_we),
    .wr_addr   (cfg_addr),
    .wr_data   (cfg_data),
    .frame_wrap(frame_wrap),
    .act       (act)
  );

  rt_scan_counter u_cnt (
    .clk       (clk),
    .rst_n     (rst_n),
    .h_last    (act.h_last),
    .v_last    (act.v_last),
    .x_q       (cx),
    .y_q       (cy),
    .frame_wrap(frame_wrap)
  );

  // Per-axis compare operands
  cnt_t             ax_pos      [NAX];
  cnt_t             ax_sync_end [NAX];
  cnt_t             ax_vis_beg  [NAX];
  cnt_t             ax_vis_end  [NAX];
  logic [NAX-1:0]   ax_en;
  logic [NAX-1:0]   sync_q;
  logic [NAX-1:0]   win_q;

  always_comb begin
    ax_pos[0]      = cx;
    ax_pos[1]      = cy;
    ax_sync_end[0] = act.h_sync_end;
    ax_sync_end[1] = act.v_sync_end;
    ax_vis_beg[0]  = act.h_vis_beg;
    ax_vis_beg[1]  = act.v_vis_beg;
    ax_vis_end[0]  = act.h_vis_end;
    ax_vis_end[1]  = act.v_vis_end;
    ax_en[0]       = 1'b1;
    // vertical flags step only where the horizontal sync starts
    ax_en[1]       = (cx == '0);
  end

  for (genvar g = 0; g < NAX; g++) begin : g_axis
    rt_span #(.RST_Q(1'b1)) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .en   (ax_en[g]),
      .pos  (ax_pos[g]),
      .beg  ('0),
      .fin  (ax_sync_end[g]),
      .q    (sync_q[g])
    );
    rt_span #(.RST_Q(1'b0)) u_win (
      .clk  (clk),
      .rst_n(rst_n),
      .en   (ax_en[g]),
      .pos  (ax_pos[g]),
      .beg  (ax_vis_beg[g]),
      .fin  (ax_vis_end[g]),
      .q    (win_q[g])
    );
  end

  // Coordinate and polarity registers, aligned with the flag registers
  cnt_t           pix_q, pix_d;
  cnt_t           line_q, line_d;
  logic [NAX-1:0] pol_q, pol_d;
  logic           pol_load;

  assign pol_load = (cx == '0) && (cy == '0);

  always_comb begin
    pix_d  = cx;
    line_d = cy;
    pol_d  = pol_q;
    if (pol_load) begin
      pol_d = {act.v_hi, act.h_hi};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pix_q  <= '0;
      line_q <= '0;
      pol_q  <= {RST_V_HI, RST_H_HI};
    end else begin
      pix_q  <= pix_d;
      line_q <= line_d;
      pol_q  <= pol_d;
    end
  end

  assign pix_x   = pix_q;
  assign line_y  = line_q;
  assign hsync   = pol_q[0] ? sync_q[0] : ~sync_q[0];
  assign vsync   = pol_q[1] ? sync_q[1] : ~sync_q[1];
  assign visible = win_q[0] & win_q[1];

  // R6: a vertical sync edge always coincides with a horizontal sync start
  p_vs_on_hs_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_q[1] != $past(sync_q[1])) |-> $rose(sync_q[0]));

  // R7: the visible window never overlaps the horizontal sync
  p_vis_out_of_sync_r7: assert property (@(posedge clk) disable iff (!rst_n)
    visible |-> !sync_q[0]);

  // R8: polarity only changes on the first pixel of a frame
  p_pol_frame_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (pol_q != $past(pol_q)) |-> (pix_x == '0 && line_y == '0));

endmodule

// File: tb/test_raster_timer.sv
module test_raster_timer;

  // field order in a mode: htot hsync hback hvis vtot vsync vback vvis hhi vhi
  localparam int NF = 10;
  localparam int SMALL [NF] = '{24, 3, 4, 12, 10, 2, 2, 5, 0, 0};
  localparam int DFLT  [NF] = '{695, 56, 121, 500, 417, 3, 25, 378, 0, 0};
  localparam int NMODE = 5;
  localparam int MODES [NMODE][NF] = '{
    '{24, 3, 4, 12, 10, 2, 2, 5, 1, 0},   // polarity swap (R8)
    '{24, 3, 6, 12, 10, 2, 2, 5, 0, 1},   // porch shift, same total (R9)
    '{24, 3, 6, 12, 20, 4, 4, 10, 1, 1},  // line doubled (R10)
    '{19, 3, 4, 12, 9, 2, 2, 5, 0, 0},    // zero front porch (R7)
    '{30, 5, 3, 20, 14, 3, 1, 8, 1, 0}    // general mode (R2)
  };

  logic        clk;
  logic        rst_n;
  logic        cfg_we;
  logic [2:0]  cfg_addr;
  logic [13:0] cfg_data;
  logic        s_hs, s_vs, s_vis, d_hs, d_vs, d_vis;
  logic [13:0] s_px, s_ln, d_px, d_ln;
  int          checks;
  int          failures;

  initial clk = 1'b0;
  always #4 clk = ~clk;

  raster_timer #(
    .RST_H_TOTAL(24), .RST_H_SYNC(3), .RST_H_BACK(4), .RST_H_VIS(12),
    .RST_V_TOTAL(10), .RST_V_SYNC(2), .RST_V_BACK(2), .RST_V_VIS(5),
    .RST_H_HI(1'b0),  .RST_V_HI(1'b0)
  ) i_raster_timer (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_data(cfg_data), .hsync(s_hs), .vsync(s_vs), .visible(s_vis),
    .pix_x(s_px), .line_y(s_ln)
  );

  raster_timer i_raster_timer_rst (
    .clk(clk), .rst_n(rst_n), .cfg_we(1'b0), .cfg_addr(3'd0),
    .cfg_data(14'd0), .hsync(d_hs), .vsync(d_vs), .visible(d_vis),
    .pix_x(d_px), .line_y(d_ln)
  );

  task automatic check(input bit ok, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  task automatic wr_mode(input int m [NF]);
    for (int k = 0; k < 8; k++) begin
      int v;
      v = m[k];
      if (k == 1) v = v | (m[8] << 13);
      if (k == 5) v = v | (m[9] << 13);
      cfg_we   = 1'b1;
      cfg_addr = 3'(k);
      cfg_data = 14'(v);
      @(negedge clk);
    end
    cfg_we = 1'b0;
  endtask

  // Walks ncyc cycles from pixel 0 of line 0, comparing each cycle with the model of mode c.
  task automatic scan(input int sel, input int c [NF], input int ncyc, input string tag);
    int ex, ey;
    int e_xy, e_hs, e_vs, e_al, e_vi;
    int a_xy, x_xy, a_hs, x_hs, a_vs, x_vs, a_vi, x_vi;
    logic phs, pvs;
    ex = 0; ey = 0; e_xy = 0; e_hs = 0; e_vs = 0; e_al = 0; e_vi = 0;
    a_xy = 0; x_xy = 0; a_hs = 0; x_hs = 0; a_vs = 0; x_vs = 0; a_vi = 0; x_vi = 0;
    phs = 1'b0; pvs = 1'b0;
    for (int n = 0; n < ncyc; n++) begin
      logic o_hs, o_vs, o_vi;
      int   o_x, o_y, hb, vb;
      bit   hact, vact, e_h, e_v, e_w;
      if (sel == 0) begin
        o_hs = s_hs; o_vs = s_vs; o_vi = s_vis; o_x = int'(s_px); o_y = int'(s_ln);
      end else begin
        o_hs = d_hs; o_vs = d_vs; o_vi = d_vis; o_x = int'(d_px); o_y = int'(d_ln);
      end
      hb   = c[1] + c[2];
      vb   = c[5] + c[6];
      hact = (ex < c[1]);
      vact = (ey < c[5]);
      e_h  = (c[8] != 0) ? hact : !hact;
      e_v  = (c[9] != 0) ? vact : !vact;
      e_w  = (ex >= hb) && (ex < hb + c[3]) && (ey >= vb) && (ey < vb + c[7]);
      if (o_x != ex || o_y != ey) begin
        if (e_xy == 0) begin a_xy = o_x * 10000 + o_y; x_xy = ex * 10000 + ey; end
        e_xy++;
      end
      if (o_hs != e_h) begin
        if (e_hs == 0) begin a_hs = o_hs; x_hs = e_h; end
        e_hs++;
      end
      if (o_vs != e_v) begin
        if (e_vs == 0) begin a_vs = o_vs; x_vs = e_v; end
        e_vs++;
      end
      if (o_vi != e_w) begin
        if (e_vi == 0) begin a_vi = o_vi; x_vi = e_w; end
        e_vi++;
      end
      if (n > 0 && o_vs != pvs && !(o_hs != phs && o_hs == (c[8] != 0))) e_al++;
      phs = o_hs;
      pvs = o_vs;
      if (ex == c[0] - 1) begin
        ex = 0;
        ey = (ey == c[4] - 1) ? 0 : ey + 1;
      end else begin
        ex++;
      end
      @(negedge clk);
    end
    check(e_xy == 0, {tag, " R4 coordinates (x*10000+y)"}, a_xy, x_xy);
    check(e_hs == 0, {tag, " R5 hsync level"}, a_hs, x_hs);
    check(e_vs == 0, {tag, " R6 vsync level"}, a_vs, x_vs);
    check(e_al == 0, {tag, " R6 vsync edge off hsync start (count)"}, e_al, 0);
    check(e_vi == 0, {tag, " R7 visible flag"}, a_vi, x_vi);
  endtask

  function automatic string mode_tag(input int i);
    case (i)
      0:       return "R3 old frame kept / R8 polarity swap next";
      1:       return "R3 old frame kept / R9 porch shift next";
      2:       return "R3 old frame kept / R10 doubled next";
      3:       return "R3 old frame kept / zero porch next";
      default: return "R3 old frame kept / general mode next";
    endcase
  endfunction

  function automatic string run_tag(input int i);
    case (i)
      0:       return "R8 polarity swap";
      1:       return "R9 porch shift";
      2:       return "R10 line doubled";
      3:       return "R7 zero front porch";
      default: return "R2 general mode";
    endcase
  endfunction

  initial begin
    #(8 * 150000);
    checks++;
    failures++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int cur [NF];
    checks = 0;
    failures = 0;
    rst_n = 1'b0;
    cfg_we = 1'b0;
    cfg_addr = 3'd0;
    cfg_data = 14'd0;
    repeat (3) @(negedge clk);

    // R1: reset state of both instances
    check(s_px == 0 && s_ln == 0, "R1 reset coordinates small", int'(s_px), 0);
    check(s_hs == 1'b0 && s_vs == 1'b0, "R1 reset syncs small (active-low asserted)", int'({s_hs, s_vs}), 0);
    check(s_vis == 1'b0, "R1 reset visible small", int'(s_vis), 0);
    check(d_px == 0 && d_ln == 0, "R1 reset coordinates default", int'(d_px), 0);
    check(d_hs == 1'b0 && d_vs == 1'b0, "R1 reset syncs default (active-low asserted)", int'({d_hs, d_vs}), 0);
    check(d_vis == 1'b0, "R1 reset visible default", int'(d_vis), 0);

    rst_n = 1'b1;
    fork
      begin
        // R1: default mode through the first visible line and beyond
        scan(1, DFLT, 30 * 695, "R1 default mode");
      end
      begin
        cur = SMALL;
        for (int i = 0; i < NMODE; i++) begin
          int nxt [NF];
          nxt = MODES[i];
          fork
            scan(0, cur, cur[0] * cur[4], mode_tag(i));
            wr_mode(nxt);
          join
          cur = nxt;
          scan(0, cur, cur[0] * cur[4], run_tag(i));
          // the run above ends at pixel 0 of the next frame, still in this mode
        end
      end
    join

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule